// File: doc/BRIEF.md
# Wide-State Keyless Permutation Engine

This block computes a fixed 512-bit keyless permutation built from AES-style round steps. The 64 input bytes form an 8-by-8 byte grid. A variant select picks one of two permutations, P or Q. Both use the same round structure and differ only in their constants and row rotations. A hashing datapath uses the block as its heavy primitive: it loads a state, waits ten cycles and takes back the permuted state. Everything around that is out of scope: padding, chaining values, feed-forward XORs and truncation.

Every round runs four steps in a fixed order. The first adds the round-dependent constants. The second passes every byte through the AES substitution box. The third rotates each row left by its own number of byte positions. The fourth multiplies each column by a circulant matrix over GF(2^8). The block does one round per clock cycle and keeps the state in a single register.

The interface is a start/ready handshake with a done pulse. While the engine is idle it accepts a start and captures the input state and the variant at the same edge. Ten round edges follow, then done pulses. The result stays on the output until the next accepted start.

Top module: `perm512_engine`

## Requirements
- R1: While reset is high and in the cycle after it, ready_o is 1, done_o is 0 and state_o is all zeros.
- R2: start_i is accepted only at a clock edge where ready_o is 1. From that edge on, ready_o stays 0 for the ten cycles in which rounds are computed.
- R3: done_o is high for exactly one cycle. That cycle begins at the 10th clock edge after the edge that accepted start_i. ready_o is 1 in the done cycle.
- R4: From the done cycle until the next accepted start, state_o does not change.
- R5: A start_i asserted while ready_o is 0 is ignored. The running computation keeps its result and its timing.
- R6: Bytes are mapped column-major. Byte k of state_i counts from the most significant end (bits 511..504 is byte 0) and goes to row k mod 8, column k div 8. state_o uses the same mapping.
- R7: With mode_i = 0 (variant P), round i (0..9) XORs (j<<4) XOR i into byte (row 0, column j) and leaves the other bytes unchanged. Row r is then rotated left by r positions.
- R8: With mode_i = 1 (variant Q), round i XORs ff into every byte of rows 0..6 and ff XOR (j<<4) XOR i into byte (row 7, column j). Rows 0..7 are then rotated left by 1,3,5,7,0,2,4,6 positions.
- R9: The substitution step applies the standard AES S-box to each byte (for example 00→63, 01→7c, 53→ed).
- R10: The mixing step maps each column a to b, with b[i] = XOR over k of c[(k−i) mod 8]·a[k]. The coefficients are c = 02,02,03,04,05,03,05,07, and products are reduced by the polynomial 0x11B.
- R11: mode_i is sampled only at the accepting edge. Changes to it during a run have no effect on the result.
- R12: A start_i asserted in the done cycle is accepted, and the next run begins at once with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a permutation |
| ready_o | output | 1 | Engine idle, start will be accepted |
| mode_i | input | 1 | Variant select: 0 = P, 1 = Q |
| state_i | input | 512 | Input state, column-major bytes |
| state_o | output | 512 | Current/result state, column-major bytes |
| done_o | output | 1 | One-cycle pulse when the result is on state_o |

## Verification
Two events can fall in the same cycle: the done pulse that ends one run, and the accepted start that begins the next. The bench provokes this by raising start_i in the very cycle it sees done_o. It then checks three things: the first result was valid in that cycle, the second run keeps the ten-round latency, and the second result matches the model. A second collision comes from a start and a variant change injected halfway through a busy run. It is judged by the final result and the done timing, which must be the same as for an undisturbed run.

// File: rtl/perm512_pkg.sv
package perm512_pkg;

    localparam int ROWS    = 8;
    localparam int COLS    = 8;
    localparam int BYTE_W  = 8;
    localparam int ROUNDS  = 10;
    localparam int STATE_W = ROWS * COLS * BYTE_W;
    localparam int RND_W   = $clog2(ROUNDS + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [COLS-1:0]  row_t;
    typedef row_t  [ROWS-1:0]  grid_t;   // grid[row][col]
    typedef byte_t [ROWS-1:0]  col_t;    // col[row]

    typedef enum logic {VAR_P = 1'b0, VAR_Q = 1'b1} variant_e;

    function automatic byte_t xtime(byte_t a);
        return a[7] ? byte_t'((a << 1) ^ 8'h1b) : byte_t'(a << 1);
    endfunction

    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xtime(x);
        end
        return acc;
    endfunction

    // a^254 by square and multiply; maps 0 to 0
    function automatic byte_t gf_inv(byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(byte_t x, int n);
        return byte_t'((x << n) | (x >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox(byte_t a);
        byte_t v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic int shift_amt(variant_e v, int r);
        if (v == VAR_P) return r;
        return (2 * r + ((r < ROWS / 2) ? 1 : 0)) % COLS;
    endfunction

    function automatic byte_t rc_byte(variant_e v, int r, int c, logic [RND_W-1:0] rnd);
        byte_t k = byte_t'(c << 4) ^ byte_t'(rnd);
        if (v == VAR_P) return (r == 0) ? k : 8'h00;
        return (r == ROWS - 1) ? (8'hff ^ k) : 8'hff;
    endfunction

    function automatic byte_t mix_coef(int d);
        case (d)
            0, 1:    return 8'h02;
            2, 5:    return 8'h03;
            3:       return 8'h04;
            4, 6:    return 8'h05;
            default: return 8'h07;
        endcase
    endfunction

    function automatic grid_t unpack_grid(logic [STATE_W-1:0] v);
        grid_t g;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                g[r][c] = v[STATE_W-1-BYTE_W*(c*ROWS+r) -: BYTE_W];
        return g;
    endfunction

    function automatic logic [STATE_W-1:0] pack_grid(grid_t g);
        logic [STATE_W-1:0] v;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                v[STATE_W-1-BYTE_W*(c*ROWS+r) -: BYTE_W] = g[r][c];
        return v;
    endfunction

endpackage

// File: rtl/perm_mix_col.sv
module perm_mix_col
    import perm512_pkg::*;
(
    input  col_t col_i,
    output col_t col_o
);
    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            col_o[i] = '0;
            for (int k = 0; k < ROWS; k++)
                col_o[i] = col_o[i] ^ gmul(mix_coef((k - i + ROWS) % ROWS), col_i[k]);
        end
    end
endmodule

// File: rtl/perm_round.sv
module perm_round
    import perm512_pkg::*;
(
    input  grid_t            st_i,
    input  variant_e         var_i,
    input  logic [RND_W-1:0] rnd_i,
    output grid_t            st_o
);
    grid_t sub;
    grid_t shifted;
    col_t  col_in  [COLS];
    col_t  col_out [COLS];

    always_comb begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                sub[r][c] = sbox(st_i[r][c] ^ rc_byte(var_i, r, c, rnd_i));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                shifted[r][c] = sub[r][(c + shift_amt(var_i, r)) % COLS];
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                col_in[c][r] = shifted[r][c];
    end

    for (genvar gc = 0; gc < COLS; gc++) begin : g_col
        perm_mix_col u_mix (
            .col_i (col_in[gc]),
            .col_o (col_out[gc])
        );
    end

    always_comb begin
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                st_o[r][c] = col_out[c][r];
    end
endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
    import perm512_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic [RND_W-1:0] rnd_o,
    output logic             done_o
);
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    logic             busy_q;
    logic [RND_W-1:0] rnd_q;
    logic             done_q;

    assign accept_o = start_i && !busy_q;
    assign busy_o   = busy_q;
    assign rnd_o    = rnd_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (busy_q) begin
                rnd_q <= rnd_q + 1'b1;
                if (rnd_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/perm512_engine.sv
module perm512_engine
    import perm512_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    output logic               ready_o,
    input  logic               mode_i,
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] state_o,
    output logic               done_o
);
    grid_t            cur_q;
    grid_t            nxt;
    variant_e         var_q;
    logic             accept;
    logic             busy;
    logic [RND_W-1:0] rnd;

    perm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .rnd_o    (rnd),
        .done_o   (done_o)
    );

    perm_round u_round (
        .st_i  (cur_q),
        .var_i (var_q),
        .rnd_i (rnd),
        .st_o  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            var_q <= VAR_P;
        end else if (accept) begin
            cur_q <= unpack_grid(state_i);
            var_q <= variant_e'(mode_i);
        end else if (busy) begin
            cur_q <= nxt;
        end
    end

    assign ready_o = !busy;
    assign state_o = pack_grid(cur_q);
endmodule

// File: rtl/perm512_checks.sv
module perm512_checks
    import perm512_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               ready_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);
    logic [7:0] busy_cyc;

    always_ff @(posedge clk) begin
        if (rst)                          busy_cyc <= '0;
        else if (start_i && ready_o)      busy_cyc <= '0;
        else if (!ready_o && busy_cyc != 8'hff) busy_cyc <= busy_cyc + 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ready_o && !done_o && state_o == '0));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> !ready_o);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_ready_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ready_o);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cyc == 8'(ROUNDS)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> $stable(state_o));
endmodule

bind perm512_engine perm512_checks u_checks (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/tb_perm512_engine.sv
`timescale 1ns/1ps
module tb_perm512_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [511:0] state_i = '0;
    logic         ready_o;
    logic         done_o;
    logic [511:0] state_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] sb_tab [256];
    int sigp [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
    int sigq [8] = '{1, 3, 5, 7, 0, 2, 4, 6};
    logic [7:0] cf [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};

    always #2 clk = ~clk;

    perm512_engine dut (
        .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
        .mode_i(mode_i), .state_i(state_i), .state_o(state_o), .done_o(done_o)
    );

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] o;
            if (a != 0)
                for (int b = 1; b < 256; b++)
                    if (ref_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (((8'h63 >> i) & 1) != 0);
            sb_tab[a] = o;
        end
    endtask

    function automatic logic [511:0] ref_perm(logic [511:0] v, bit q);
        logic [7:0] g [8][8];
        logic [7:0] t [8][8];
        logic [511:0] o;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                g[r][c] = v[511 - 8*(c*8+r) -: 8];
        for (int rd = 0; rd < 10; rd++) begin
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    if (!q) begin
                        if (r == 0) g[r][c] = g[r][c] ^ 8'(c*16) ^ 8'(rd);
                    end else begin
                        g[r][c] = g[r][c] ^ 8'hff;
                        if (r == 7) g[r][c] = g[r][c] ^ 8'(c*16) ^ 8'(rd);
                    end
                    g[r][c] = sb_tab[g[r][c]];
                end
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                    t[r][c] = g[r][(c + (q ? sigq[r] : sigp[r])) % 8];
            for (int c = 0; c < 8; c++)
                for (int i = 0; i < 8; i++) begin
                    logic [7:0] acc = 8'h00;
                    for (int k = 0; k < 8; k++)
                        acc = acc ^ ref_mul(cf[(k - i + 8) % 8], t[k][c]);
                    g[i][c] = acc;
                end
        end
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                o[511 - 8*(c*8+r) -: 8] = g[r][c];
        return o;
    endfunction

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Starts at a negedge; returns at the negedge where done_o is seen.
    task automatic do_run(input logic [511:0] din, input bit q, input int inject_at,
                          input logic [511:0] alt, output logic [511:0] res,
                          output int lat, output int rdy_hi);
        start_i = 1'b1; state_i = din; mode_i = q;
        @(negedge clk);
        start_i = 1'b0; lat = 1; rdy_hi = ready_o ? 1 : 0;
        while (!done_o && lat < 40) begin
            if (inject_at != 0) begin
                mode_i = ~q;
                if (lat == inject_at) begin start_i = 1'b1; state_i = alt; end
                else start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (!done_o && ready_o) rdy_hi++;
        end
        start_i = 1'b0;
        res = state_o;
    endtask

    task automatic full_case(logic [511:0] din, bit q, string tag);
        logic [511:0] res;
        logic [511:0] held;
        int lat, rh;
        do_run(din, q, 0, '0, res, lat, rh);
        chk(res == ref_perm(din, q), tag, res, ref_perm(din, q));
        chk(lat == 11, "R3 latency", 512'(lat), 512'd11);
        chk(rh == 0, "R2 ready low while busy", 512'(rh), 512'd0);
        held = state_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R3 done one cycle", 512'(done_o), 512'd0);
        repeat (3) @(negedge clk);
        chk(state_o == held, "R4 output held", state_o, held);
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] a, b, r1, r2;
        int lat, rh;
        void'($urandom(32'h5eed_1234));
        build_sbox();
        chk(sb_tab[8'h00] == 8'h63, "R9 sbox 00", 512'(sb_tab[8'h00]), 512'h63);
        chk(sb_tab[8'h01] == 8'h7c, "R9 sbox 01", 512'(sb_tab[8'h01]), 512'h7c);
        chk(sb_tab[8'h53] == 8'hed, "R9 sbox 53", 512'(sb_tab[8'h53]), 512'hed);

        repeat (3) @(negedge clk);
        chk(ready_o == 1'b1 && done_o == 1'b0 && state_o == '0, "R1 reset state",
            {state_o[509:0], ready_o, done_o}, 512'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(ready_o == 1'b1 && done_o == 1'b0, "R1 idle after reset",
            512'({ready_o, done_o}), 512'b10);

        full_case('0, 1'b0, "R7 P zero");
        full_case('0, 1'b1, "R8 Q zero");
        full_case({512{1'b1}}, 1'b0, "R7 P ones");
        full_case({512{1'b1}}, 1'b1, "R8 Q ones");
        full_case({8'h01, 504'h0}, 1'b0, "R6 msb byte P");
        full_case({504'h0, 8'h80}, 1'b1, "R6 lsb byte Q");
        for (int n = 0; n < 10; n++) begin
            full_case(rand512(), 1'b0, "R7 R9 R10 random P");
            full_case(rand512(), 1'b1, "R8 R9 R10 random Q");
        end

        // R5 and R11: start and variant flip while busy
        a = rand512(); b = rand512();
        do_run(a, 1'b0, 3, b, r1, lat, rh);
        chk(r1 == ref_perm(a, 1'b0), "R5 R11 busy start ignored P", r1, ref_perm(a, 1'b0));
        chk(lat == 11, "R5 latency kept", 512'(lat), 512'd11);
        @(negedge clk);
        a = rand512(); b = rand512();
        do_run(a, 1'b1, 6, b, r1, lat, rh);
        chk(r1 == ref_perm(a, 1'b1), "R5 R11 busy start ignored Q", r1, ref_perm(a, 1'b1));
        @(negedge clk);

        // R12: new start in the done cycle
        a = rand512(); b = rand512();
        do_run(a, 1'b1, 0, '0, r1, lat, rh);
        chk(ready_o == 1'b1, "R3 ready in done cycle", 512'(ready_o), 512'd1);
        chk(r1 == ref_perm(a, 1'b1), "R12 first result", r1, ref_perm(a, 1'b1));
        do_run(b, 1'b0, 0, '0, r2, lat, rh);
        chk(lat == 11, "R12 back-to-back latency", 512'(lat), 512'd11);
        chk(r2 == ref_perm(b, 1'b0), "R12 second result", r2, ref_perm(b, 1'b0));
        @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule